// File: doc/BRIEF.md
# Inter-processor flag handshake registers

This block carries one-way event signalling between two processors that share a clock. The sending core has its own register port. It raises any of 32 flags by writing ones to a set register. It sees the flags through a read-only view. It can withdraw flags through a clear register.

The receiving core has a second register port. It sees the same storage through a status view and retires flags by writing ones to an acknowledge register. Both clear paths act on one store. A read from either view returns the identical word.

Flags are numbered 1 to 32, and flag N is bit N-1. The lowest four flags also drive level interrupt lines toward the receiver. The remaining flags can only be polled. The intended use has four steps:
1. The sender raises a flag.
2. The receiver polls the flag or takes its interrupt.
3. The receiver handles the message.
4. The receiver acknowledges, which drops the flag in both views.

Top module: `ipc_flag_regs`

## Requirements
- R1: After the asynchronous reset, all 32 flags read 0 in both views, both read data outputs are 0 and every interrupt line is low.
- R2: A sender write to address 1 (set) makes flag bit k equal 1 for every bit k written as 1. Bits written as 0 leave their flags unchanged, and the flags stay set until cleared.
- R3: A read of sender address 0 (flag view) and a read of receiver address 0 (status view) return the same 32-bit value.
- R4: A receiver write to address 1 (acknowledge) clears flag bit k for every bit k written as 1. Bits written as 0 have no effect, and the change appears in both views.
- R5: A sender write to address 2 (clear) clears flag bit k for every bit k written as 1, exactly as an acknowledge does.
- R6: irq_o[i] equals flag bit i for i in 0..3. It is low in the cycle after the edge that takes a clearing write and high in the cycle after the edge that takes a setting write. Flags 5 to 32 drive no interrupt.
- R7: When a set and a clear for the same bit are taken on the same edge, the bit ends up 1. Bits cleared without a set end up 0.
- R8: Set, clear and acknowledge addresses, sender address 3 and receiver addresses 2 and 3 read back as 0. Writes to sender address 0 or receiver address 0 change no flag.
- R9: Read data is registered. The value on a read data output in a cycle is the register selected by that port's address at the previous edge, as it stood before any write taken on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_addr_i | input | 2 | Sender register address |
| s_we_i | input | 1 | Sender write enable |
| s_wdata_i | input | 32 | Sender write data |
| s_rdata_o | output | 32 | Sender read data, one-cycle latency |
| r_addr_i | input | 2 | Receiver register address |
| r_we_i | input | 1 | Receiver write enable |
| r_wdata_i | input | 32 | Receiver write data |
| r_rdata_o | output | 32 | Receiver read data, one-cycle latency |
| irq_o | output | 4 | Level interrupts for flags 1 to 4 |

## Verification
The bench builds the block with its default 32 flags and 4 interrupt lines, a size small enough to walk every bit.

It raises and then retires each flag one at a time. The retire step alternates between the acknowledge path and the clear path, and after every step the bench compares both views and all interrupt lines against an arithmetic model. That covers every bit position, including the boundary between interrupt-capable and poll-only flags.

Directed cases add simultaneous set and acknowledge of overlapping masks, all-zero writes, writes to the read-only views and reads of every address. A status read issued on the same edge as a set shows the one-cycle read timing.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;
  localparam int unsigned ADDR_W = 2;
  // sender port map
  localparam logic [ADDR_W-1:0] A_S_VIEW = 2'd0;
  localparam logic [ADDR_W-1:0] A_S_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] A_S_CLR  = 2'd2;
  // receiver port map
  localparam logic [ADDR_W-1:0] A_R_VIEW = 2'd0;
  localparam logic [ADDR_W-1:0] A_R_ACK  = 2'd1;
endpackage

// File: rtl/ipc_bus_port.sv
module ipc_bus_port
  import ipc_flag_pkg::*;
#(
  parameter bit          SENDER = 1'b1,
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] set_o,
  output logic [FLAG_W-1:0] clr_o,
  output logic [FLAG_W-1:0] rdata_o
);
  logic              view_hit;
  logic [FLAG_W-1:0] rdata_q;

  generate
    if (SENDER) begin : g_snd
      assign set_o    = (we_i && addr_i == A_S_SET) ? wdata_i : '0;
      assign clr_o    = (we_i && addr_i == A_S_CLR) ? wdata_i : '0;
      assign view_hit = (addr_i == A_S_VIEW);
    end else begin : g_rcv
      assign set_o    = '0;
      assign clr_o    = (we_i && addr_i == A_R_ACK) ? wdata_i : '0;
      assign view_hit = (addr_i == A_R_VIEW);
    end
  endgenerate

  // write-only and unmapped addresses read zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= view_hit ? flags_i : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ipc_flag_store.sv
module ipc_flag_store #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] flags_nxt_o
);
  logic [FLAG_W-1:0] flags_q;

  // set applied after clear: a colliding set survives
  assign flags_nxt_o = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nxt_o;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ipc_irq_out.sv
module ipc_irq_out #(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] flag_nxt_i,
  output logic [IRQ_W-1:0] irq_o
);
  logic [IRQ_W-1:0] irq_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[i] <= 1'b0;
      else         irq_q[i] <= flag_nxt_i[i];
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ipc_flag_regs.sv
module ipc_flag_regs
  import ipc_flag_pkg::*;
#(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned IRQ_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic              s_we_i,
  input  logic [FLAG_W-1:0] s_wdata_i,
  output logic [FLAG_W-1:0] s_rdata_o,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic [FLAG_W-1:0] r_wdata_i,
  output logic [FLAG_W-1:0] r_rdata_o,
  output logic [IRQ_W-1:0]  irq_o
);
  logic [FLAG_W-1:0] s_set, s_clr, r_set, r_clr;
  logic [FLAG_W-1:0] flags_q, flags_nxt;

  ipc_bus_port #(.SENDER(1'b1), .FLAG_W(FLAG_W)) u_snd (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(s_addr_i), .we_i(s_we_i),
    .wdata_i(s_wdata_i), .flags_i(flags_q), .set_o(s_set), .clr_o(s_clr),
    .rdata_o(s_rdata_o)
  );

  ipc_bus_port #(.SENDER(1'b0), .FLAG_W(FLAG_W)) u_rcv (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(r_addr_i), .we_i(r_we_i),
    .wdata_i(r_wdata_i), .flags_i(flags_q), .set_o(r_set), .clr_o(r_clr),
    .rdata_o(r_rdata_o)
  );

  ipc_flag_store #(.FLAG_W(FLAG_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(s_set | r_set),
    .clr_i(s_clr | r_clr), .flags_o(flags_q), .flags_nxt_o(flags_nxt)
  );

  ipc_irq_out #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flag_nxt_i(flags_nxt[IRQ_W-1:0]),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/ipc_flag_regs_chk.sv
module ipc_flag_regs_chk
  import ipc_flag_pkg::*;
#(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned IRQ_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] s_addr_i,
  input logic              s_we_i,
  input logic [FLAG_W-1:0] s_wdata_i,
  input logic [FLAG_W-1:0] s_rdata_o,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_we_i,
  input logic [FLAG_W-1:0] r_wdata_i,
  input logic [FLAG_W-1:0] r_rdata_o,
  input logic [IRQ_W-1:0]  irq_o,
  input logic [FLAG_W-1:0] flags_i
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_we_i && s_addr_i == A_S_SET) |=>
      ((flags_i & $past(s_wdata_i)) == $past(s_wdata_i)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_we_i && !r_we_i) |=> $stable(flags_i));

  p_view_same_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_addr_i == A_S_VIEW && r_addr_i == A_R_VIEW) |=> (s_rdata_o == r_rdata_o));

  p_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_we_i && r_addr_i == A_R_ACK && !(s_we_i && s_addr_i == A_S_SET)) |=>
      ((flags_i & $past(r_wdata_i)) == '0));

  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_we_i && s_addr_i == A_S_CLR) |=> ((flags_i & $past(s_wdata_i)) == '0));

  p_irq_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == flags_i[IRQ_W-1:0]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_we_i && s_addr_i == A_S_SET && r_we_i && r_addr_i == A_R_ACK) |=>
      ((flags_i & $past(s_wdata_i)) == $past(s_wdata_i)));

  p_ro_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_we_i && s_addr_i == A_S_VIEW && !r_we_i) |=> $stable(flags_i));

  p_read_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (s_rdata_o == (($past(s_addr_i) == A_S_VIEW) ? $past(flags_i) : '0)));
endmodule

bind ipc_flag_regs ipc_flag_regs_chk #(.FLAG_W(FLAG_W), .IRQ_W(IRQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_addr_i(s_addr_i), .s_we_i(s_we_i),
  .s_wdata_i(s_wdata_i), .s_rdata_o(s_rdata_o), .r_addr_i(r_addr_i),
  .r_we_i(r_we_i), .r_wdata_i(r_wdata_i), .r_rdata_o(r_rdata_o),
  .irq_o(irq_o), .flags_i(flags_q)
);

// File: tb/ipc_flag_regs_tb_top.sv
module ipc_flag_regs_tb_top;
  localparam int CLK_P  = 10;
  localparam int FLAG_W = 32;
  localparam int IRQ_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        s_addr = 2'd0, r_addr = 2'd0;
  logic              s_we = 1'b0, r_we = 1'b0;
  logic [FLAG_W-1:0] s_wdata = '0, r_wdata = '0;
  logic [FLAG_W-1:0] s_rdata, r_rdata;
  logic [IRQ_W-1:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [FLAG_W-1:0] model = '0;
  logic [FLAG_W-1:0] rd;

  always #(CLK_P/2) clk = ~clk;

  ipc_flag_regs #(.FLAG_W(FLAG_W), .IRQ_W(IRQ_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .s_addr_i(s_addr), .s_we_i(s_we),
    .s_wdata_i(s_wdata), .s_rdata_o(s_rdata), .r_addr_i(r_addr), .r_we_i(r_we),
    .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [FLAG_W-1:0] got,
                       input logic [FLAG_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit snd, input logic [1:0] a, input logic [FLAG_W-1:0] d);
    if (snd) begin s_we = 1'b1; s_addr = a; s_wdata = d; end
    else     begin r_we = 1'b1; r_addr = a; r_wdata = d; end
    tick();
    s_we = 1'b0; r_we = 1'b0;
  endtask

  task automatic rd_s(input logic [1:0] a, output logic [FLAG_W-1:0] d);
    s_addr = a; tick(); d = s_rdata;
  endtask

  task automatic rd_r(input logic [1:0] a, output logic [FLAG_W-1:0] d);
    r_addr = a; tick(); d = r_rdata;
  endtask

  task automatic views(input string req);
    rd_s(2'd0, rd); check({req, " flag view"}, rd, model);
    rd_r(2'd0, rd); check({req, " status view R3"}, rd, model);
    check({req, " irq R6"}, {{(FLAG_W-IRQ_W){1'b0}}, irq}, model & 32'hF);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 sender rdata", s_rdata, '0);
    check("R1 receiver rdata", r_rdata, '0);
    check("R1 irq", {28'd0, irq}, '0);
    rst_ni = 1'b1;
    tick();
    views("R1");

    // walk each flag up, cumulatively
    for (int i = 0; i < FLAG_W; i++) begin
      wr(1'b1, 2'd1, 32'd1 << i);
      model |= 32'd1 << i;
      check("R2/R6 irq after set", {28'd0, irq}, model & 32'hF);
      views("R2");
    end
    wr(1'b1, 2'd1, '0);
    views("R2 zero set");
    wr(1'b0, 2'd1, '0);
    views("R4 zero ack");

    // walk each flag down: ack for even, sender clear for odd
    for (int i = 0; i < FLAG_W; i++) begin
      if (i % 2 == 0) wr(1'b0, 2'd1, 32'd1 << i);
      else            wr(1'b1, 2'd2, 32'd1 << i);
      model &= ~(32'd1 << i);
      check((i % 2 == 0) ? "R4/R6 irq after ack" : "R5/R6 irq after clear",
            {28'd0, irq}, model & 32'hF);
      views((i % 2 == 0) ? "R4" : "R5");
    end

    // patterns
    wr(1'b1, 2'd1, 32'hA5A5_0F0F); model = 32'hA5A5_0F0F; views("R2 pattern");
    wr(1'b0, 2'd1, 32'h0000_FFFF); model = 32'hA5A5_0000; views("R4 pattern");
    wr(1'b1, 2'd1, 32'h0000_0010); model |= 32'h10;       views("R6 poll-only");

    // collision: set and ack on the same edge
    wr(1'b1, 2'd2, '1); model = '0;
    wr(1'b1, 2'd1, 32'h0000_000F); model = 32'hF;
    s_we = 1'b1; s_addr = 2'd1; s_wdata = 32'h0000_00F3;
    r_we = 1'b1; r_addr = 2'd1; r_wdata = 32'h0000_00FF;
    tick();
    s_we = 1'b0; r_we = 1'b0;
    model = 32'h0000_00F3;
    check("R7 irq after collision", {28'd0, irq}, 32'h3);
    views("R7");

    // read-only views ignore writes, write-only regs read zero
    wr(1'b1, 2'd0, '1); views("R8 sender view write");
    wr(1'b0, 2'd0, '1); views("R8 status write");
    rd_s(2'd1, rd); check("R8 set reads zero", rd, '0);
    rd_s(2'd2, rd); check("R8 clear reads zero", rd, '0);
    rd_s(2'd3, rd); check("R8 sender addr3 zero", rd, '0);
    rd_r(2'd1, rd); check("R8 ack reads zero", rd, '0);
    rd_r(2'd2, rd); check("R8 receiver addr2 zero", rd, '0);

    // read latency: status read on the same edge as a set shows old value
    r_addr = 2'd0;
    wr(1'b1, 2'd1, 32'h8000_0000);
    check("R9 old value on same-edge read", r_rdata, model);
    model |= 32'h8000_0000;
    tick();
    check("R9 new value next cycle", r_rdata, model);

    // async reset clears everything
    rst_ni = 1'b0;
    #1;
    check("R1 irq in reset", {28'd0, irq}, '0);
    check("R1 rdata in reset", s_rdata, '0);
    @(negedge clk); rst_ni = 1'b1; model = '0;
    views("R1 after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule